// File: doc/BRIEF.md
# SMBus Transaction Sequencer

This block runs one complete SMBus-style transaction on a byte-level I2C master engine. The host fills a 32-entry data buffer and presents a request with a handshake. The request holds a 7-bit target address, a direction flag, a command byte, a transfer kind and a block length. The sequencer checks the request first. It then issues start, repeated-start, byte-send, byte-receive and stop requests to the engine, each as a one-cycle pulse. After each request it waits for the engine's response event.

Received bytes are written into the buffer in arrival order. The host reads them back through the same indexed port once the done pulse has fired. The sequencer handles four fault cases: a negative acknowledge from the target, a bus error, loss of bus ownership, and an engine that stays silent too long. Each fault produces a defined result code. The sequencer also sends a clear or reset request to the engine where the fault calls for one.

Top module: `smbus_seq`

## Requirements
- R1: A request is rejected with result 1 (invalid), a done pulse and no engine request in any of these cases: a kind code above 4, a block kind whose length is 0 or greater than 32, or a read whose data length is zero. Result codes are 0 ok, 1 invalid, 2 no-device, 3 I/O error. Kind codes are 0 quick (no data), 1 byte (one byte), 2 byte-data (one byte), 3 word-data (two bytes) and 4 block (length taken from the request).
- R2: req_ready_o is high only in idle. busy_o is high from the cycle after acceptance through the cycle of the done pulse. done_o lasts exactly one cycle and carries result_o.
- R3: The address byte sent on the bus is the 7-bit address in bits 7:1, with the direction in bit 0 (1 = read).
- R4: Quick and byte kinds send start and then the address byte with its real direction bit, with no command phase. A byte-kind write sends the command value as its only data byte.
- R5: Byte-data, word-data and block kinds send start, the address with bit 0 cleared, then the command byte. A read follows with a repeated start, the address with bit 0 set, and the receives. A write continues straight into its data bytes.
- R6: Write data goes out in buffer index order starting at 0. Received bytes are stored from index 0 upward. For word-data, index 0 is the low byte.
- R7: Each receive request carries a last flag. The flag is set only on the final byte of the read, which is the byte to be answered with a negative acknowledge.
- R8: After the final data byte, or after the address when no data follows, the sequencer requests stop without a clear and returns result 0.
- R9: A negative acknowledge in any phase leads to a stop request together with a flag-clear request, then result 2, with no reset request.
- R10: A bus-error event, or any event that arrives while the ownership input is low, ends the transaction with result 3 and a reset request in the done cycle. No stop is requested.
- R11: If no event arrives within TIMEOUT_CYC cycles of waiting, the result is 3 with a reset request. An event in the last cycle of the window still counts as on time.
- R12: Host writes to the buffer while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Ready to accept a request (idle) |
| req_addr_i | input | 7 | Target 7-bit address |
| req_read_i | input | 1 | 1 = read, 0 = write |
| req_cmd_i | input | 8 | Command byte |
| req_kind_i | input | 3 | Transfer kind code |
| req_len_i | input | 6 | Block length (block kind only) |
| buf_we_i | input | 1 | Host buffer write strobe |
| buf_idx_i | input | 5 | Host buffer index |
| buf_wdata_i | input | 8 | Host buffer write data |
| buf_rdata_o | output | 8 | Buffer contents at buf_idx_i |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 2 | Result code, valid with done_o |
| eng_start_o | output | 1 | Request start or repeated start |
| eng_stop_o | output | 1 | Request stop |
| eng_clr_o | output | 1 | Request clearing of event flags |
| eng_reset_o | output | 1 | Request engine reset |
| eng_tx_o | output | 1 | Request a byte send |
| eng_tx_data_o | output | 8 | Byte to send |
| eng_rx_o | output | 1 | Request a byte receive |
| eng_rx_last_o | output | 1 | Answer this received byte with a negative acknowledge |
| ev_done_i | input | 1 | Engine finished the current request |
| ev_nack_i | input | 1 | Target returned a negative acknowledge |
| ev_berr_i | input | 1 | Bus error |
| ev_master_i | input | 1 | Engine still owns the bus |
| ev_rx_data_i | input | 8 | Received byte, valid with ev_done_i |

## Verification
Two cases are the hardest to reach from the ports: the timeout boundary and a fault striking one exact step of a long sequence. The bench's engine responder counts the requests it receives. It can withhold its answer or send a chosen fault on a selected request number, so a negative acknowledge, bus error or ownership loss can be placed on the address, the command or any data byte. For the timeout, it answers exactly TIMEOUT_CYC cycles late in one run and never in another. The bench then checks that the gap from the last request to done is one cycle longer than the window.

// File: rtl/smbus_seq_pkg.sv
package smbus_seq_pkg;

  typedef enum logic [2:0] {
    K_QUICK = 3'd0,
    K_BYTE  = 3'd1,
    K_BDATA = 3'd2,
    K_WORD  = 3'd3,
    K_BLOCK = 3'd4
  } kind_e;

  typedef enum logic [1:0] {
    RES_OK    = 2'd0,
    RES_INVAL = 2'd1,
    RES_NODEV = 2'd2,
    RES_IOERR = 2'd3
  } res_e;

  typedef enum logic [2:0] {
    PH_START,
    PH_ADDR_W,
    PH_CMD,
    PH_RSTART,
    PH_ADDR,
    PH_TX,
    PH_RX
  } phase_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_WAIT,
    ST_STOP,
    ST_DONE
  } state_e;

endpackage

// File: rtl/smbus_seq_buf.sv
module smbus_seq_buf #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned W     = 8,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  logic [W-1:0]     wdata_i,
  input  logic [IDX_W-1:0] ridx_a_i,
  output logic [W-1:0]     rdata_a_o,
  input  logic [IDX_W-1:0] ridx_b_i,
  output logic [W-1:0]     rdata_b_o
);

  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[widx_i] <= wdata_i;
    end
  end

  assign rdata_a_o = mem_q[ridx_a_i];
  assign rdata_b_o = mem_q[ridx_b_i];

endmodule

// File: rtl/smbus_seq_wdog.sv
module smbus_seq_wdog #(
  parameter int unsigned TIMEOUT_CYC = 20_000_000,
  localparam int unsigned CNT_W = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic fire_o
);

  logic [CNT_W-1:0] cnt_q;

  assign fire_o = run_i && (cnt_q == CNT_W'(TIMEOUT_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!run_i || fire_o) cnt_q <= '0;
    else                       cnt_q <= cnt_q + CNT_W'(1);
  end

  assert_wdog_bound_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(TIMEOUT_CYC));

endmodule

// File: rtl/smbus_seq_ctrl.sv
module smbus_seq_ctrl
  import smbus_seq_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned LEN_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             ready_o,
  input  logic [6:0]       req_addr_i,
  input  logic             req_read_i,
  input  logic [7:0]       req_cmd_i,
  input  logic [2:0]       req_kind_i,
  input  logic [LEN_W-1:0] req_len_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [1:0]       result_o,
  output logic             eng_start_o,
  output logic             eng_stop_o,
  output logic             eng_clr_o,
  output logic             eng_reset_o,
  output logic             eng_tx_o,
  output logic [7:0]       eng_tx_data_o,
  output logic             eng_rx_o,
  output logic             eng_rx_last_o,
  input  logic             ev_done_i,
  input  logic             ev_nack_i,
  input  logic             ev_berr_i,
  input  logic             ev_master_i,
  input  logic [7:0]       ev_rx_data_i,
  input  logic             wd_fire_i,
  output logic             wd_run_o,
  output logic [IDX_W-1:0] tx_idx_o,
  input  logic [7:0]       tx_byte_i,
  output logic             rx_we_o,
  output logic [IDX_W-1:0] rx_idx_o,
  output logic [7:0]       rx_data_o
);

  state_e           state_q;
  phase_e           phase_q, phase_nxt;
  res_e             res_q;
  logic [6:0]       addr_q;
  logic             rd_q, short_q, nack_q;
  logic [7:0]       cmd_q;
  logic [LEN_W-1:0] len_q, idx_q, idx_n, req_len;
  logic             req_ok, ev_any, data_ph, fin;

  assign ev_any  = ev_done_i | ev_nack_i | ev_berr_i;
  assign data_ph = (phase_q == PH_TX) || (phase_q == PH_RX);
  assign idx_n   = idx_q + LEN_W'(data_ph);

  // request length and validation
  always_comb begin
    req_ok = 1'b1;
    case (kind_e'(req_kind_i))
      K_QUICK:         req_len = '0;
      K_BYTE, K_BDATA: req_len = LEN_W'(1);
      K_WORD:          req_len = LEN_W'(2);
      K_BLOCK: begin
        req_len = req_len_i;
        if (req_len_i == '0 || req_len_i > LEN_W'(DEPTH)) req_ok = 1'b0;
      end
      default: begin
        req_len = '0;
        req_ok  = 1'b0;
      end
    endcase
    if (req_read_i && req_len == '0) req_ok = 1'b0;
  end

  // phase sequencing after a completed step
  always_comb begin
    phase_nxt = phase_q;
    fin       = 1'b0;
    case (phase_q)
      PH_START:  phase_nxt = short_q ? PH_ADDR : PH_ADDR_W;
      PH_ADDR_W: phase_nxt = PH_CMD;
      PH_CMD: begin
        phase_nxt = rd_q ? PH_RSTART : PH_TX;
        fin       = !rd_q && (len_q == '0);
      end
      PH_RSTART: phase_nxt = PH_ADDR;
      PH_ADDR: begin
        phase_nxt = rd_q ? PH_RX : PH_TX;
        fin       = !rd_q && (len_q == '0);
      end
      PH_TX, PH_RX: fin = (idx_n == len_q);
      default: fin = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      phase_q <= PH_START;
      res_q   <= RES_OK;
      addr_q  <= '0;
      rd_q    <= 1'b0;
      short_q <= 1'b0;
      nack_q  <= 1'b0;
      cmd_q   <= '0;
      len_q   <= '0;
      idx_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (req_valid_i) begin
          addr_q  <= req_addr_i;
          rd_q    <= req_read_i;
          cmd_q   <= req_cmd_i;
          short_q <= (req_kind_i == K_QUICK) || (req_kind_i == K_BYTE);
          len_q   <= req_len;
          idx_q   <= '0;
          phase_q <= PH_START;
          nack_q  <= 1'b0;
          if (req_ok) begin
            state_q <= ST_CMD;
          end else begin
            res_q   <= RES_INVAL;
            state_q <= ST_DONE;
          end
        end
        ST_CMD: state_q <= ST_WAIT;
        ST_WAIT: begin
          if (ev_any) begin
            if (ev_berr_i || !ev_master_i) begin
              res_q   <= RES_IOERR;
              state_q <= ST_DONE;
            end else if (ev_nack_i) begin
              res_q   <= RES_NODEV;
              nack_q  <= 1'b1;
              state_q <= ST_STOP;
            end else begin
              idx_q <= idx_n;
              if (fin) begin
                res_q   <= RES_OK;
                state_q <= ST_STOP;
              end else begin
                phase_q <= phase_nxt;
                state_q <= ST_CMD;
              end
            end
          end else if (wd_fire_i) begin
            res_q   <= RES_IOERR;
            state_q <= ST_DONE;
          end
        end
        ST_STOP: state_q <= ST_DONE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  logic issue;
  assign issue = (state_q == ST_CMD);

  assign ready_o     = (state_q == ST_IDLE);
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = (state_q == ST_DONE);
  assign result_o    = res_q;
  assign eng_start_o = issue && (phase_q == PH_START || phase_q == PH_RSTART);
  assign eng_tx_o    = issue && (phase_q == PH_ADDR_W || phase_q == PH_CMD ||
                                 phase_q == PH_ADDR   || phase_q == PH_TX);
  assign eng_rx_o      = issue && (phase_q == PH_RX);
  assign eng_rx_last_o = eng_rx_o && (idx_q == len_q - LEN_W'(1));
  assign eng_stop_o    = (state_q == ST_STOP);
  assign eng_clr_o     = eng_stop_o && nack_q;
  assign eng_reset_o   = done_o && (res_q == RES_IOERR);

  always_comb begin
    case (phase_q)
      PH_ADDR_W: eng_tx_data_o = {addr_q, 1'b0};
      PH_CMD:    eng_tx_data_o = cmd_q;
      PH_ADDR:   eng_tx_data_o = {addr_q, rd_q};
      PH_TX:     eng_tx_data_o = short_q ? cmd_q : tx_byte_i;
      default:   eng_tx_data_o = '0;
    endcase
  end

  assign wd_run_o  = (state_q == ST_WAIT) && !ev_any;
  assign tx_idx_o  = idx_q[IDX_W-1:0];
  assign rx_idx_o  = idx_q[IDX_W-1:0];
  assign rx_data_o = ev_rx_data_i;
  assign rx_we_o   = (state_q == ST_WAIT) && (phase_q == PH_RX) && ev_done_i &&
                     !ev_nack_i && !ev_berr_i && ev_master_i;

  assert_one_cmd_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({eng_start_o, eng_stop_o, eng_tx_o, eng_rx_o}));

  assert_done_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_accept_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && req_valid_i) |=> busy_o);

  assert_nack_stop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_WAIT) && ev_nack_i && !ev_berr_i && ev_master_i)
      |=> (eng_stop_o && eng_clr_o));

  assert_fault_reset_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_WAIT) && ev_any && (ev_berr_i || !ev_master_i))
      |=> (done_o && eng_reset_o && !eng_stop_o));

endmodule

// File: rtl/smbus_seq.sv
module smbus_seq
  import smbus_seq_pkg::*;
#(
  parameter int unsigned DEPTH       = 32,
  parameter int unsigned TIMEOUT_CYC = 20_000_000,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned LEN_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [6:0]       req_addr_i,
  input  logic             req_read_i,
  input  logic [7:0]       req_cmd_i,
  input  logic [2:0]       req_kind_i,
  input  logic [LEN_W-1:0] req_len_i,
  input  logic             buf_we_i,
  input  logic [IDX_W-1:0] buf_idx_i,
  input  logic [7:0]       buf_wdata_i,
  output logic [7:0]       buf_rdata_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [1:0]       result_o,
  output logic             eng_start_o,
  output logic             eng_stop_o,
  output logic             eng_clr_o,
  output logic             eng_reset_o,
  output logic             eng_tx_o,
  output logic [7:0]       eng_tx_data_o,
  output logic             eng_rx_o,
  output logic             eng_rx_last_o,
  input  logic             ev_done_i,
  input  logic             ev_nack_i,
  input  logic             ev_berr_i,
  input  logic             ev_master_i,
  input  logic [7:0]       ev_rx_data_i
);

  logic             wd_run, wd_fire, rx_we, host_we, mem_we;
  logic [IDX_W-1:0] tx_idx, rx_idx, mem_widx;
  logic [7:0]       tx_byte, rx_data, mem_wdata;

  // host writes land only while idle
  assign host_we   = buf_we_i && req_ready_o;
  assign mem_we    = rx_we || host_we;
  assign mem_widx  = rx_we ? rx_idx  : buf_idx_i;
  assign mem_wdata = rx_we ? rx_data : buf_wdata_i;

  smbus_seq_buf #(.DEPTH(DEPTH), .W(8)) i_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (mem_we),
    .widx_i    (mem_widx),
    .wdata_i   (mem_wdata),
    .ridx_a_i  (buf_idx_i),
    .rdata_a_o (buf_rdata_o),
    .ridx_b_i  (tx_idx),
    .rdata_b_o (tx_byte)
  );

  smbus_seq_wdog #(.TIMEOUT_CYC(TIMEOUT_CYC)) i_wdog (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (wd_run),
    .fire_o (wd_fire)
  );

  smbus_seq_ctrl #(.DEPTH(DEPTH)) i_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_valid_i   (req_valid_i),
    .ready_o       (req_ready_o),
    .req_addr_i    (req_addr_i),
    .req_read_i    (req_read_i),
    .req_cmd_i     (req_cmd_i),
    .req_kind_i    (req_kind_i),
    .req_len_i     (req_len_i),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .result_o      (result_o),
    .eng_start_o   (eng_start_o),
    .eng_stop_o    (eng_stop_o),
    .eng_clr_o     (eng_clr_o),
    .eng_reset_o   (eng_reset_o),
    .eng_tx_o      (eng_tx_o),
    .eng_tx_data_o (eng_tx_data_o),
    .eng_rx_o      (eng_rx_o),
    .eng_rx_last_o (eng_rx_last_o),
    .ev_done_i     (ev_done_i),
    .ev_nack_i     (ev_nack_i),
    .ev_berr_i     (ev_berr_i),
    .ev_master_i   (ev_master_i),
    .ev_rx_data_i  (ev_rx_data_i),
    .wd_fire_i     (wd_fire),
    .wd_run_o      (wd_run),
    .tx_idx_o      (tx_idx),
    .tx_byte_i     (tx_byte),
    .rx_we_o       (rx_we),
    .rx_idx_o      (rx_idx),
    .rx_data_o     (rx_data)
  );

  assert_no_host_write_busy_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && mem_we) |-> rx_we);

endmodule

// File: tb/test_smbus_seq.sv
module test_smbus_seq;

  localparam int T = 20;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_valid_i = 1'b0;
  logic       req_ready_o;
  logic [6:0] req_addr_i = '0;
  logic       req_read_i = 1'b0;
  logic [7:0] req_cmd_i = '0;
  logic [2:0] req_kind_i = '0;
  logic [5:0] req_len_i = '0;
  logic       buf_we_i = 1'b0;
  logic [4:0] buf_idx_i = '0;
  logic [7:0] buf_wdata_i = '0;
  logic [7:0] buf_rdata_o;
  logic       busy_o, done_o;
  logic [1:0] result_o;
  logic       eng_start_o, eng_stop_o, eng_clr_o, eng_reset_o;
  logic       eng_tx_o, eng_rx_o, eng_rx_last_o;
  logic [7:0] eng_tx_data_o;
  logic       ev_done_i = 1'b0, ev_nack_i = 1'b0, ev_berr_i = 1'b0, ev_master_i = 1'b1;
  logic [7:0] ev_rx_data_i = '0;

  always #5 clk_i = ~clk_i;

  smbus_seq #(.DEPTH(32), .TIMEOUT_CYC(T)) i_smbus_seq (.*);

  int checks = 0, errors = 0;
  int cyc = 0, cmd_no = 0, rx_cnt = 0, pend = 0, pend_kind = 0, rst_cnt = 0;
  int fault = 0, fault_at = 99, rsp_delay = 2, last_cmd_cyc = 0, done_cyc = 0;
  logic [7:0] pend_data = '0;
  logic [7:0] wbuf [32];
  int log_q[$];
  logic exp_busy = 1'b0, prev_done = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // engine responder and per-cycle handshake monitor
  always @(negedge clk_i) begin
    cyc++;
    if (rst_ni) begin
      checks++;
      if (busy_o !== exp_busy || req_ready_o !== !exp_busy || (done_o && prev_done)) begin
        errors++;
        $display("FAIL R2 busy/ready/done actual=%0b%0b%0b expected=%0b%0b", busy_o, req_ready_o,
                 done_o, exp_busy, !exp_busy);
      end
      if (done_o) exp_busy = 1'b0;
      else if (req_valid_i && req_ready_o) exp_busy = 1'b1;
      prev_done = done_o;
    end
    ev_done_i = 1'b0; ev_nack_i = 1'b0; ev_berr_i = 1'b0; ev_master_i = 1'b1;
    if (pend > 0) begin
      pend--;
      if (pend == 0) begin
        case (pend_kind)
          1: ev_nack_i = 1'b1;
          2: ev_berr_i = 1'b1;
          3: begin ev_done_i = 1'b1; ev_master_i = 1'b0; end
          default: begin ev_done_i = 1'b1; ev_rx_data_i = pend_data; end
        endcase
      end
    end
    if (eng_start_o || eng_tx_o || eng_rx_o) begin
      if (eng_start_o) log_q.push_back('h100);
      if (eng_tx_o) log_q.push_back('h300 | int'(eng_tx_data_o));
      if (eng_rx_o) begin
        log_q.push_back('h400 | int'(eng_rx_last_o));
        pend_data = 8'h30 + 8'(rx_cnt);
        rx_cnt++;
      end
      last_cmd_cyc = cyc;
      if (cmd_no == fault_at && fault == 4) pend = 0;
      else begin
        pend = rsp_delay;
        pend_kind = (cmd_no == fault_at) ? fault : 0;
      end
      cmd_no++;
    end
    if (eng_stop_o) log_q.push_back('h200 | int'(eng_clr_o));
    if (eng_reset_o) rst_cnt++;
    if (done_o) done_cyc = cyc;
  end

  task automatic load(input int i, input logic [7:0] v);
    @(posedge clk_i); #1;
    buf_we_i = 1'b1; buf_idx_i = 5'(i); buf_wdata_i = v; wbuf[i] = v;
    @(posedge clk_i); #1;
    buf_we_i = 1'b0;
  endtask

  // kind: 0 quick 1 byte 2 byte-data 3 word 4 block; flt: 0 none 1 nack 2 berr 3 lost master 4 silent
  task automatic do_txn(input string tag, input int kind, input bit rd, input logic [6:0] addr,
                        input logic [7:0] cmd, input int blen, input int flt, input int flt_at,
                        input int dly, input bit poke);
    int exp_q[$];
    int len, exp_res, exp_rst, n, bad;
    bit ok;
    len = (kind == 0) ? 0 : (kind == 1 || kind == 2) ? 1 : (kind == 3) ? 2 : (kind == 4) ? blen : 0;
    ok = (kind <= 4) && !(kind == 4 && (blen == 0 || blen > 32)) && !(rd && len == 0);
    exp_rst = 0;
    exp_res = 1;
    if (ok) begin
      exp_q.push_back('h100);
      if (kind <= 1) begin
        exp_q.push_back('h300 | int'({addr, rd}));
        if (rd) for (int i = 0; i < len; i++) exp_q.push_back('h400 | int'(i == len - 1));
        else if (kind == 1) exp_q.push_back('h300 | int'(cmd));
      end else begin
        exp_q.push_back('h300 | int'({addr, 1'b0}));
        exp_q.push_back('h300 | int'(cmd));
        if (rd) begin
          exp_q.push_back('h100);
          exp_q.push_back('h300 | int'({addr, 1'b1}));
          for (int i = 0; i < len; i++) exp_q.push_back('h400 | int'(i == len - 1));
        end else begin
          for (int i = 0; i < len; i++) exp_q.push_back('h300 | int'(wbuf[i]));
        end
      end
      if (flt != 0 && flt_at < exp_q.size()) begin
        while (exp_q.size() > flt_at + 1) void'(exp_q.pop_back());
        if (flt == 1) begin exp_q.push_back('h201); exp_res = 2; end
        else begin exp_res = 3; exp_rst = 1; end
      end else begin
        exp_q.push_back('h200);
        exp_res = 0;
      end
    end
    @(posedge clk_i); #1;
    log_q.delete(); cmd_no = 0; rx_cnt = 0; rst_cnt = 0; pend = 0;
    fault = flt; fault_at = flt_at; rsp_delay = dly;
    req_addr_i = addr; req_read_i = rd; req_cmd_i = cmd; req_kind_i = 3'(kind);
    req_len_i = 6'(blen); req_valid_i = 1'b1;
    @(posedge clk_i); #1;
    req_valid_i = 1'b0;
    if (poke) begin
      buf_we_i = 1'b1; buf_idx_i = 5'd0; buf_wdata_i = 8'hEE;
      @(posedge clk_i); #1;
      buf_we_i = 1'b0;
    end
    n = 0;
    do begin @(negedge clk_i); n++; end while (!done_o && n < 5000);
    chk(done_o === 1'b1 && int'(result_o) == exp_res, tag, "result", int'(result_o), exp_res);
    @(posedge clk_i); #1;
    chk(log_q.size() == exp_q.size(), tag, "request count", log_q.size(), exp_q.size());
    bad = -1;
    for (int i = 0; i < exp_q.size() && i < log_q.size(); i++)
      if (bad < 0 && log_q[i] != exp_q[i]) bad = i;
    if (bad >= 0) chk(1'b0, tag, "request sequence", log_q[bad], exp_q[bad]);
    else chk(1'b1, tag, "request sequence", 0, 0);
    chk(rst_cnt == exp_rst, tag, "reset request", rst_cnt, exp_rst);
    if (ok && flt == 4) chk(done_cyc - last_cmd_cyc == T + 1, tag, "timeout gap",
                            done_cyc - last_cmd_cyc, T + 1);
    if (ok && rd && exp_res == 0)
      for (int i = 0; i < len; i++) begin
        @(posedge clk_i); #1; buf_idx_i = 5'(i);
        @(negedge clk_i);
        chk(buf_rdata_o == 8'h30 + 8'(i), tag, "read data", int'(buf_rdata_o), 'h30 + i);
      end
    if (poke) begin
      @(posedge clk_i); #1; buf_idx_i = 5'd0;
      @(negedge clk_i);
      chk(buf_rdata_o == wbuf[0], tag, "buffer after busy write", int'(buf_rdata_o), int'(wbuf[0]));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) wbuf[i] = '0;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk(req_ready_o && !busy_o && !done_o && log_q.size() == 0, "R2", "reset state",
        {req_ready_o, busy_o, done_o}, 3'b100);

    do_txn("R4 R8 R3 quick write", 0, 0, 7'h50, 8'h00, 0, 0, 99, 2, 0);
    do_txn("R4 byte write", 1, 0, 7'h2C, 8'h5A, 0, 0, 99, 1, 0);
    do_txn("R4 R7 byte read", 1, 1, 7'h13, 8'h77, 0, 0, 99, 2, 0);
    load(0, 8'h91);
    do_txn("R5 byte-data write", 2, 0, 7'h48, 8'h05, 0, 0, 99, 2, 0);
    load(0, 8'h34); load(1, 8'h12);
    do_txn("R6 word write", 3, 0, 7'h3A, 8'h10, 0, 0, 99, 3, 0);
    do_txn("R5 R6 R7 word read", 3, 1, 7'h3A, 8'h11, 0, 0, 99, 2, 0);
    do_txn("R7 R6 block read 32", 4, 1, 7'h51, 8'h20, 32, 0, 99, 1, 0);
    load(0, 8'hA1); load(1, 8'hB2); load(2, 8'hC3);
    do_txn("R6 R8 block write", 4, 0, 7'h22, 8'h40, 3, 0, 99, 2, 0);
    do_txn("R1 bad kind", 5, 0, 7'h22, 8'h40, 3, 0, 99, 2, 0);
    do_txn("R1 block len 0", 4, 0, 7'h22, 8'h40, 0, 0, 99, 2, 0);
    do_txn("R1 block len 33", 4, 1, 7'h22, 8'h40, 33, 0, 99, 2, 0);
    do_txn("R1 quick read", 0, 1, 7'h22, 8'h40, 0, 0, 99, 2, 0);
    do_txn("R9 nack on address", 2, 1, 7'h61, 8'h01, 0, 1, 1, 2, 0);
    do_txn("R9 nack on data", 3, 0, 7'h61, 8'h02, 0, 1, 3, 2, 0);
    do_txn("R10 bus error", 4, 1, 7'h0F, 8'h03, 4, 2, 2, 2, 0);
    do_txn("R10 lost master", 3, 1, 7'h0F, 8'h04, 0, 3, 4, 2, 0);
    do_txn("R11 silent engine", 2, 0, 7'h0E, 8'h05, 0, 4, 3, 2, 0);
    do_txn("R11 reply at limit", 4, 0, 7'h0E, 8'h06, 2, 0, 99, T, 0);
    load(0, 8'h11);
    do_txn("R12 write while busy", 4, 0, 7'h33, 8'h07, 1, 0, 99, 5, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule